// File: doc/BRIEF.md
# Floating I/O Interrupt Queue Controller

This block is a central holding unit for interrupts that are not bound to any one processor. Any processor may take the next interrupt from it. It keeps one queue per I/O interruption subclass, eight in all. Each queued entry carries a subchannel identifier, a subchannel number, a 32-bit parameter and a 32-bit interruption word. Beside the queues it holds one accumulated service-signal parameter and a single machine-check / channel-report flag.

Producers inject I/O interrupts, service signals and machine-check reports through separate strobes. A consumer takes an I/O interrupt by presenting an 8-bit subclass enable mask. The block gives back the newest entry of the lowest enabled, non-empty subclass, with a one-cycle valid pulse on the cycle after the request. A selective clear removes every queued I/O entry that carries a given identifier/number pair. A summary pending vector, an "any pending" output and a masked I/O pending output let a consumer see whether it has work to do. Each queue has a fixed depth. An inject into a full queue is dropped and reported through a sticky per-subclass overflow bit.

Top module: `flq_ctrl`

## Requirements
- R1: The subclass of an injected I/O entry is bits 29:27 of `io_inj_word`. After the inject, `pend_vec[subclass]` is 1 on the following cycle.
- R2: Within one subclass, entries are delivered newest first: a dequeue returns the entry injected most recently among those still queued.
- R3: A dequeue request scans subclasses upward from 0 and takes the first one whose `io_deq_mask` bit is 1 and whose queue is non-empty. On the next cycle `io_deq_valid` pulses for one cycle with that entry and `io_deq_sub`. If no subclass qualifies, `io_deq_miss` pulses instead and no queue changes.
- R4: `pend_vec[s]` (bits 0..7) is 1 exactly while queue s holds at least one entry. It falls on the cycle after a dequeue or clear empties the queue.
- R5: A clear request removes, from all eight queues, every entry whose identifier and number both equal `clr_id`/`clr_nr`. The remaining entries keep their order, and a clear that matches nothing changes nothing.
- R6: Each queue holds DEPTH entries (default 4). An inject into a queue that stays full after the same cycle's removals is dropped and leaves the queue unchanged. It sets `ovf_vec[subclass]`, which stays 1 until reset.
- R7: A service inject ORs `svc_inj_parm` into an accumulator and sets `pend_vec[8]`. A service dequeue while that bit is 1 pulses `svc_deq_valid` on the next cycle with the accumulated value, and clears the accumulator and the bit. When an inject falls in the same cycle as that dequeue, the dequeue returns the old value and only the new parameter is kept.
- R8: A machine-check inject sets `pend_vec[9]`, and a machine-check dequeue clears it. When both fall in the same cycle, the bit stays 1.
- R9: `any_pending` is the OR of all ten bits of `pend_vec`. `io_pend_masked` is 1 when any of `pend_vec[7:0]` has its `io_deq_mask` bit set.
- R10: When an I/O inject falls in the same cycle as a dequeue or clear, the dequeue and clear act on the queue contents from before that edge. The new entry then goes to the head and is never removed by that clear. Fullness is judged after the removals.
- R11: While `rst_n` is low, all queues are emptied and every pending bit, overflow bit and output pulse is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_inj_valid | input | 1 | Inject one I/O entry this cycle |
| io_inj_id | input | 16 | Subchannel identifier of the injected entry |
| io_inj_nr | input | 16 | Subchannel number of the injected entry |
| io_inj_parm | input | 32 | Interruption parameter of the injected entry |
| io_inj_word | input | 32 | Interruption word; bits 29:27 select the subclass |
| svc_inj_valid | input | 1 | Inject a service signal |
| svc_inj_parm | input | 32 | Parameter ORed into the service accumulator |
| mc_inj_valid | input | 1 | Raise the machine-check / channel-report flag |
| io_deq_req | input | 1 | Request one I/O entry |
| io_deq_mask | input | 8 | Subclass enable mask, bit s enables subclass s |
| io_deq_valid | output | 1 | One-cycle pulse: dequeued entry on the outputs below |
| io_deq_miss | output | 1 | One-cycle pulse: request found no enabled entry |
| io_deq_sub | output | 3 | Subclass of the dequeued entry |
| io_deq_id | output | 16 | Identifier of the dequeued entry |
| io_deq_nr | output | 16 | Number of the dequeued entry |
| io_deq_parm | output | 32 | Parameter of the dequeued entry |
| io_deq_word | output | 32 | Interruption word of the dequeued entry |
| svc_deq_req | input | 1 | Take the accumulated service parameter |
| svc_deq_valid | output | 1 | One-cycle pulse: service parameter valid |
| svc_deq_parm | output | 32 | Accumulated service parameter |
| mc_deq_req | input | 1 | Clear the machine-check / channel-report flag |
| clr_req | input | 1 | Remove all I/O entries matching the pair below |
| clr_id | input | 16 | Identifier to match |
| clr_nr | input | 16 | Number to match |
| pend_vec | output | 10 | Bits 0..7 subclass non-empty, bit 8 service, bit 9 machine check |
| any_pending | output | 1 | OR of all pending bits |
| io_pend_masked | output | 1 | Some subclass enabled by io_deq_mask is pending |
| ovf_vec | output | 8 | Sticky per-subclass overflow bits |

## Verification
The hard case is an I/O inject that lands in the same cycle as a dequeue or clear on the same subclass. Here the ordering rule decides which entry comes out, whether the new entry survives a clear it would match, and whether a full queue accepts it. The bench provokes this directly: it fills a queue, then injects and dequeues in one cycle, and it injects and clears a matching pair in one cycle. Its random phase then keeps identifiers and numbers in a narrow range and steers injects into a few subclasses, so these collisions recur often. Every cycle, a bench model applies removals before insertion and judges fullness after the removals, and the dequeued entry, the pending vector and the overflow bits are compared against it.

// File: rtl/flq_pkg.sv
package flq_pkg;
  parameter int unsigned NSUB    = 8;
  parameter int unsigned SUB_W   = $clog2(NSUB);
  parameter int unsigned ID_W    = 16;
  parameter int unsigned NR_W    = 16;
  parameter int unsigned PARM_W  = 32;
  parameter int unsigned WORD_W  = 32;
  parameter int unsigned SUB_LSB = 27;
  parameter int unsigned PEND_W  = NSUB + 2;
  parameter int unsigned SVC_BIT = NSUB;
  parameter int unsigned MC_BIT  = NSUB + 1;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [NR_W-1:0]   nr;
    logic [PARM_W-1:0] parm;
    logic [WORD_W-1:0] word;
  } io_ent_t;

  // subclass field of an interruption word
  function automatic logic [SUB_W-1:0] word_sub(input logic [WORD_W-1:0] w);
    return w[SUB_LSB +: SUB_W];
  endfunction

  // subchannel pair compare used by the selective clear
  function automatic logic ent_match(input io_ent_t e,
                                     input logic [ID_W-1:0] id,
                                     input logic [NR_W-1:0] nr);
    return (e.id == id) && (e.nr == nr);
  endfunction

  // isolate the lowest set bit
  function automatic logic [NSUB-1:0] lowest_one(input logic [NSUB-1:0] v);
    return v & (~v + NSUB'(1));
  endfunction

  function automatic logic [SUB_W-1:0] onehot_idx(input logic [NSUB-1:0] oh);
    logic [SUB_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < int'(NSUB); i++) begin
      if (oh[i]) idx = idx | SUB_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/flq_lane.sv
module flq_lane
  import flq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  io_ent_t         push_ent_i,
  input  logic            pop_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] clr_id_i,
  input  logic [NR_W-1:0] clr_nr_i,
  output io_ent_t         head_o,
  output logic            nonempty_o,
  output logic            ovf_o,
  output logic            drop_o
);
  // slot 0 is the newest entry; valid slots always form a prefix
  io_ent_t          ent_q [DEPTH];
  io_ent_t          ent_n [DEPTH];
  logic [DEPTH-1:0] vld_q, vld_n, keep;
  logic             ovf_q, accept;
  int unsigned      kept_cnt, total, running;
  int unsigned      rank [DEPTH];

  always_comb begin
    kept_cnt = 0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      keep[i] = vld_q[i]
              && !(pop_i && (i == 0))
              && !(clr_i && ent_match(ent_q[i], clr_id_i, clr_nr_i));
      if (keep[i]) kept_cnt = kept_cnt + 1;
    end
    // fullness judged after this cycle's removals
    accept  = push_i && (kept_cnt < DEPTH);
    drop_o  = push_i && !accept;
    total   = kept_cnt + (accept ? 1 : 0);
    running = accept ? 1 : 0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      rank[i] = running;
      if (keep[i]) running = running + 1;
    end
    for (int j = 0; j < int'(DEPTH); j++) begin
      ent_n[j] = ent_q[j];
      vld_n[j] = (j < int'(total));
      if (j == 0 && accept) ent_n[j] = push_ent_i;
      for (int i = 0; i < int'(DEPTH); i++) begin
        if (keep[i] && (rank[i] == j)) ent_n[j] = ent_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ovf_q <= 1'b0;
      for (int i = 0; i < int'(DEPTH); i++) ent_q[i] <= '0;
    end else begin
      vld_q <= vld_n;
      ent_q <= ent_n;
      if (drop_o) ovf_q <= 1'b1;
    end
  end

  assign head_o     = ent_q[0];
  assign nonempty_o = vld_q[0];
  assign ovf_o      = ovf_q;

  // R2: an accepted entry becomes the head
  p_lifo_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> nonempty_o && (head_o == $past(push_ent_i)));

  // R6: overflow is sticky
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  // R6: a dropped inject leaves the full queue as it was
  p_drop_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> ovf_o && (&vld_q) && (head_o == $past(head_o)));

  // R4: popping the last entry empties the queue
  p_last_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && nonempty_o && !vld_q[DEPTH > 1 ? 1 : 0] && DEPTH > 1)
      |=> !nonempty_o);

  // R5: after a clear without a same-cycle inject, the head does not match
  p_clear_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !push_i) |=>
      !(nonempty_o && ent_match(head_o, $past(clr_id_i), $past(clr_nr_i))));
endmodule

// File: rtl/flq_pick.sv
module flq_pick
  import flq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSUB-1:0]  avail_i,
  input  logic [NSUB-1:0]  mask_i,
  output logic [NSUB-1:0]  grant_o,
  output logic             hit_o,
  output logic [SUB_W-1:0] sel_o
);
  logic [NSUB-1:0] elig;

  assign elig    = avail_i & mask_i;
  assign grant_o = lowest_one(elig);
  assign hit_o   = |elig;
  assign sel_o   = onehot_idx(grant_o);

  // R3: at most one subclass granted
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R3: grant is eligible and no lower subclass is eligible
  p_grant_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((grant_o & avail_i & mask_i) != '0)
           && (((grant_o - NSUB'(1)) & avail_i & mask_i) == '0));
endmodule

// File: rtl/flq_side.sv
module flq_side
  import flq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_inj_i,
  input  logic [PARM_W-1:0] svc_parm_i,
  input  logic              svc_deq_i,
  input  logic              mc_inj_i,
  input  logic              mc_deq_i,
  output logic              svc_pend_o,
  output logic              mc_pend_o,
  output logic              svc_valid_o,
  output logic [PARM_W-1:0] svc_parm_o
);
  logic [PARM_W-1:0] acc_q, acc_n;
  logic              svc_take;

  assign svc_take = svc_deq_i && svc_pend_o;

  always_comb begin
    acc_n = svc_take ? '0 : acc_q;
    if (svc_inj_i) acc_n = acc_n | svc_parm_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q       <= '0;
      svc_pend_o  <= 1'b0;
      mc_pend_o   <= 1'b0;
      svc_valid_o <= 1'b0;
      svc_parm_o  <= '0;
    end else begin
      acc_q       <= acc_n;
      svc_pend_o  <= (svc_pend_o && !svc_take) || svc_inj_i;
      mc_pend_o   <= (mc_pend_o && !mc_deq_i) || mc_inj_i;
      svc_valid_o <= svc_take;
      if (svc_take) svc_parm_o <= acc_q;
    end
  end

  // R7: a service dequeue without a same-cycle inject empties the accumulator
  p_svc_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_take && !svc_inj_i) |=> !svc_pend_o && (acc_q == '0));

  // R7: injects accumulate by OR
  p_svc_accum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_inj_i && !svc_deq_i) |=> svc_pend_o
      && (acc_q == ($past(acc_q) | $past(svc_parm_i))));

  // R8: inject wins over a same-cycle dequeue
  p_mc_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mc_inj_i |=> mc_pend_o);

  p_mc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_deq_i && !mc_inj_i) |=> !mc_pend_o);
endmodule

// File: rtl/flq_ctrl.sv
module flq_ctrl
  import flq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_inj_valid,
  input  logic [ID_W-1:0]   io_inj_id,
  input  logic [NR_W-1:0]   io_inj_nr,
  input  logic [PARM_W-1:0] io_inj_parm,
  input  logic [WORD_W-1:0] io_inj_word,
  input  logic              svc_inj_valid,
  input  logic [PARM_W-1:0] svc_inj_parm,
  input  logic              mc_inj_valid,
  input  logic              io_deq_req,
  input  logic [NSUB-1:0]   io_deq_mask,
  output logic              io_deq_valid,
  output logic              io_deq_miss,
  output logic [SUB_W-1:0]  io_deq_sub,
  output logic [ID_W-1:0]   io_deq_id,
  output logic [NR_W-1:0]   io_deq_nr,
  output logic [PARM_W-1:0] io_deq_parm,
  output logic [WORD_W-1:0] io_deq_word,
  input  logic              svc_deq_req,
  output logic              svc_deq_valid,
  output logic [PARM_W-1:0] svc_deq_parm,
  input  logic              mc_deq_req,
  input  logic              clr_req,
  input  logic [ID_W-1:0]   clr_id,
  input  logic [NR_W-1:0]   clr_nr,
  output logic [PEND_W-1:0] pend_vec,
  output logic              any_pending,
  output logic              io_pend_masked,
  output logic [NSUB-1:0]   ovf_vec
);
  io_ent_t          inj_ent;
  io_ent_t          heads [NSUB];
  io_ent_t          sel_head;
  logic [SUB_W-1:0] inj_sub, sel;
  logic [NSUB-1:0]  nonempty, grant, drop_evt;
  logic             hit, svc_pend, mc_pend;

  assign inj_sub = word_sub(io_inj_word);
  assign inj_ent = '{id: io_inj_id, nr: io_inj_nr, parm: io_inj_parm, word: io_inj_word};

  flq_pick u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .avail_i (nonempty),
    .mask_i  (io_deq_mask),
    .grant_o (grant),
    .hit_o   (hit),
    .sel_o   (sel)
  );

  for (genvar s = 0; s < int'(NSUB); s++) begin : g_lane
    flq_lane #(.DEPTH(DEPTH)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (io_inj_valid && (inj_sub == SUB_W'(s))),
      .push_ent_i (inj_ent),
      .pop_i      (io_deq_req && grant[s]),
      .clr_i      (clr_req),
      .clr_id_i   (clr_id),
      .clr_nr_i   (clr_nr),
      .head_o     (heads[s]),
      .nonempty_o (nonempty[s]),
      .ovf_o      (ovf_vec[s]),
      .drop_o     (drop_evt[s])
    );
  end

  assign sel_head = heads[sel];

  flq_side u_side (
    .clk         (clk),
    .rst_n       (rst_n),
    .svc_inj_i   (svc_inj_valid),
    .svc_parm_i  (svc_inj_parm),
    .svc_deq_i   (svc_deq_req),
    .mc_inj_i    (mc_inj_valid),
    .mc_deq_i    (mc_deq_req),
    .svc_pend_o  (svc_pend),
    .mc_pend_o   (mc_pend),
    .svc_valid_o (svc_deq_valid),
    .svc_parm_o  (svc_deq_parm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_deq_valid <= 1'b0;
      io_deq_miss  <= 1'b0;
      io_deq_sub   <= '0;
      io_deq_id    <= '0;
      io_deq_nr    <= '0;
      io_deq_parm  <= '0;
      io_deq_word  <= '0;
    end else begin
      io_deq_valid <= io_deq_req && hit;
      io_deq_miss  <= io_deq_req && !hit;
      if (io_deq_req && hit) begin
        io_deq_sub  <= sel;
        io_deq_id   <= sel_head.id;
        io_deq_nr   <= sel_head.nr;
        io_deq_parm <= sel_head.parm;
        io_deq_word <= sel_head.word;
      end
    end
  end

  assign pend_vec       = {mc_pend, svc_pend, nonempty};
  assign any_pending    = |pend_vec;
  assign io_pend_masked = |(nonempty & io_deq_mask);

  // R1: an inject always leaves its subclass pending (accepted or full)
  p_inject_pends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_inj_valid |=> pend_vec[$past(inj_sub)]);

  // R3: no request, no pulse
  p_idle_deq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_deq_req |=> !io_deq_valid && !io_deq_miss);

  // R3: a hit reports the picked subclass and its head word
  p_deq_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_deq_req && hit) |=> io_deq_valid && (io_deq_sub == $past(sel))
      && (io_deq_word == $past(sel_head.word)));

  // R6: a drop is only possible in the injected subclass
  p_drop_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drop_evt) && ((drop_evt & ~(NSUB'(1) << inj_sub)) == '0));
endmodule

// File: tb/tb_flq_ctrl.sv
module tb_flq_ctrl;
  import flq_pkg::*;
  localparam int unsigned TB_DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              io_inj_valid, svc_inj_valid, mc_inj_valid;
  logic [ID_W-1:0]   io_inj_id, clr_id, io_deq_id;
  logic [NR_W-1:0]   io_inj_nr, clr_nr, io_deq_nr;
  logic [PARM_W-1:0] io_inj_parm, svc_inj_parm, io_deq_parm, svc_deq_parm;
  logic [WORD_W-1:0] io_inj_word, io_deq_word;
  logic              io_deq_req, svc_deq_req, mc_deq_req, clr_req;
  logic [NSUB-1:0]   io_deq_mask, ovf_vec;
  logic              io_deq_valid, io_deq_miss, svc_deq_valid;
  logic [SUB_W-1:0]  io_deq_sub;
  logic [PEND_W-1:0] pend_vec;
  logic              any_pending, io_pend_masked;

  flq_ctrl #(.DEPTH(TB_DEPTH)) dut (.*);

  int    n_cmp = 0, n_bad = 0;
  bit    done = 1'b0;
  string ctx = "";

  // bench model
  io_ent_t         mq [NSUB][TB_DEPTH];
  int              mcnt [NSUB];
  logic [NSUB-1:0] movf;
  logic [31:0]     msvc;
  logic            msvc_p, mmc;
  logic            e_dv, e_miss, e_sv;
  logic [2:0]      e_sub;
  io_ent_t         e_ent;
  logic [31:0]     e_sparm;

  function automatic logic [31:0] mk_word(input int sub, input logic [31:0] low);
    // subclass lives in bits 29:27 (R1)
    return {2'b00, 3'(sub), low[26:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", tag, ctx, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < int'(NSUB); s++) mcnt[s] = 0;
    movf = '0; msvc = '0; msvc_p = 1'b0; mmc = 1'b0;
    e_dv = 1'b0; e_miss = 1'b0; e_sv = 1'b0;
  endtask

  task automatic idle();
    io_inj_valid = 0; svc_inj_valid = 0; mc_inj_valid = 0;
    io_deq_req = 0; svc_deq_req = 0; mc_deq_req = 0; clr_req = 0;
    io_inj_id = '0; io_inj_nr = '0; io_inj_parm = '0; io_inj_word = '0;
    svc_inj_parm = '0; io_deq_mask = '0; clr_id = '0; clr_nr = '0;
  endtask

  task automatic model_step();
    int pick;
    io_ent_t kl [TB_DEPTH];
    int kn;
    int isub;
    pick = -1;
    e_dv = 0; e_miss = 0; e_sv = 0;
    if (io_deq_req) begin
      for (int s = 0; s < int'(NSUB); s++)
        if (pick < 0 && io_deq_mask[s] && mcnt[s] > 0) pick = s;
      if (pick >= 0) begin
        e_dv = 1; e_sub = 3'(pick); e_ent = mq[pick][0];
      end else e_miss = 1;
    end
    isub = int'(io_inj_word[29:27]);
    for (int s = 0; s < int'(NSUB); s++) begin
      kn = 0;
      for (int i = 0; i < mcnt[s]; i++) begin
        if (i == 0 && s == pick) continue;
        if (clr_req && mq[s][i].id == clr_id && mq[s][i].nr == clr_nr) continue;
        kl[kn] = mq[s][i]; kn++;
      end
      if (io_inj_valid && isub == s) begin
        if (kn < int'(TB_DEPTH)) begin
          mq[s][0] = '{id: io_inj_id, nr: io_inj_nr, parm: io_inj_parm, word: io_inj_word};
          for (int i = 0; i < kn; i++) mq[s][i+1] = kl[i];
          mcnt[s] = kn + 1;
        end else begin
          movf[s] = 1'b1;
          for (int i = 0; i < kn; i++) mq[s][i] = kl[i];
          mcnt[s] = kn;
        end
      end else begin
        for (int i = 0; i < kn; i++) mq[s][i] = kl[i];
        mcnt[s] = kn;
      end
    end
    if (svc_deq_req && msvc_p) begin
      e_sv = 1; e_sparm = msvc; msvc = '0; msvc_p = 0;
    end
    if (svc_inj_valid) begin msvc = msvc | svc_inj_parm; msvc_p = 1; end
    if (mc_deq_req) mmc = 0;
    if (mc_inj_valid) mmc = 1;
  endtask

  task automatic compare();
    logic [NSUB-1:0] ep;
    for (int s = 0; s < int'(NSUB); s++) ep[s] = (mcnt[s] > 0);
    chk("R3 deq_valid", 64'(io_deq_valid), 64'(e_dv));
    chk("R3 deq_miss", 64'(io_deq_miss), 64'(e_miss));
    if (e_dv) begin
      chk("R3 deq_sub", 64'(io_deq_sub), 64'(e_sub));
      chk("R2 deq_word", 64'(io_deq_word), 64'(e_ent.word));
      chk("R2 deq_parm", 64'(io_deq_parm), 64'(e_ent.parm));
      chk("R5 deq_idnr", 64'({io_deq_id, io_deq_nr}), 64'({e_ent.id, e_ent.nr}));
    end
    chk("R4 pend_io", 64'(pend_vec[NSUB-1:0]), 64'(ep));
    chk("R7 pend_svc", 64'(pend_vec[SVC_BIT]), 64'(msvc_p));
    chk("R8 pend_mc", 64'(pend_vec[MC_BIT]), 64'(mmc));
    chk("R6 ovf", 64'(ovf_vec), 64'(movf));
    chk("R7 svc_valid", 64'(svc_deq_valid), 64'(e_sv));
    if (e_sv) chk("R7 svc_parm", 64'(svc_deq_parm), 64'(e_sparm));
    chk("R9 any", 64'(any_pending), 64'((|ep) | msvc_p | mmc));
    chk("R9 masked", 64'(io_pend_masked), 64'(|(ep & io_deq_mask)));
  endtask

  task automatic run_cycle();
    model_step();
    @(posedge clk); #1;
    compare();
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
    compare();
  endtask

  task automatic inj(input int sub, input logic [15:0] id, input logic [15:0] nr,
                     input logic [31:0] parm, input logic [31:0] low);
    io_inj_valid = 1; io_inj_id = id; io_inj_nr = nr; io_inj_parm = parm;
    io_inj_word = mk_word(sub, low);
  endtask

  task automatic deq(input logic [7:0] mask);
    io_deq_req = 1; io_deq_mask = mask;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    @(posedge clk); #1;
    ctx = "R11 reset state";
    do_reset();

    ctx = "R1 subclass from word";
    inj(5, 16'h11, 16'h1, 32'hA5, 32'h123); run_cycle();
    chk("R1 pend5", 64'(pend_vec[5]), 64'd1);

    ctx = "R2 newest first";
    inj(2, 16'h1, 16'h1, 32'h100, 32'h1); run_cycle();
    inj(2, 16'h2, 16'h1, 32'h200, 32'h2); run_cycle();
    deq(8'h04); run_cycle();
    chk("R2 first out", 64'(io_deq_parm), 64'h200);
    deq(8'h04); run_cycle();
    chk("R2 second out", 64'(io_deq_parm), 64'h100);
    chk("R4 sub2 empty", 64'(pend_vec[2]), 64'd0);

    ctx = "R3 mask and lowest";
    inj(1, 16'h3, 16'h0, 32'h31, 32'h0); run_cycle();
    inj(3, 16'h4, 16'h0, 32'h43, 32'h0); run_cycle();
    deq(8'h08); run_cycle();
    chk("R3 picks 3", 64'(io_deq_sub), 64'd3);
    deq(8'h00); run_cycle();
    chk("R3 miss", 64'(io_deq_miss), 64'd1);
    deq(8'hFF); run_cycle();
    chk("R3 lowest is 1", 64'(io_deq_sub), 64'd1);

    ctx = "R6 overflow";
    for (int k = 0; k < 5; k++) begin inj(0, 16'h7, 16'h7, 32'(k), 32'(k)); run_cycle(); end
    chk("R6 ovf0", 64'(ovf_vec[0]), 64'd1);
    deq(8'h01); run_cycle();
    chk("R6 dropped newest", 64'(io_deq_parm), 64'd3);

    ctx = "R10 inject with dequeue on full";
    inj(0, 16'h8, 16'h8, 32'h99, 32'h9); run_cycle();
    inj(0, 16'h9, 16'h9, 32'hAA, 32'hA); deq(8'h01); run_cycle();
    chk("R10 old head out", 64'(io_deq_parm), 64'h99);
    chk("R10 no new drop", 64'(ovf_vec[1]), 64'd0);
    deq(8'h01); run_cycle();
    chk("R10 new head", 64'(io_deq_parm), 64'hAA);

    ctx = "R5 clear across subclasses";
    inj(6, 16'h5, 16'h2, 32'h61, 32'h0); run_cycle();
    inj(7, 16'h5, 16'h2, 32'h71, 32'h0); run_cycle();
    inj(7, 16'h5, 16'h3, 32'h72, 32'h0); run_cycle();
    clr_req = 1; clr_id = 16'h5; clr_nr = 16'h2;
    inj(6, 16'h5, 16'h2, 32'h62, 32'h0); run_cycle();
    chk("R10 inject survives clear", 64'(pend_vec[6]), 64'd1);
    deq(8'h80); run_cycle();
    chk("R5 survivor", 64'(io_deq_parm), 64'h72);
    clr_req = 1; clr_id = 16'hFF; clr_nr = 16'hFF; run_cycle();

    ctx = "R7 service accumulate";
    svc_inj_valid = 1; svc_inj_parm = 32'h0F; run_cycle();
    svc_inj_valid = 1; svc_inj_parm = 32'hF0; run_cycle();
    svc_deq_req = 1; svc_inj_valid = 1; svc_inj_parm = 32'h100; run_cycle();
    chk("R7 merged", 64'(svc_deq_parm), 64'hFF);
    svc_deq_req = 1; run_cycle();
    chk("R7 kept new", 64'(svc_deq_parm), 64'h100);

    ctx = "R8 machine check";
    mc_inj_valid = 1; mc_deq_req = 1; run_cycle();
    chk("R8 inject wins", 64'(pend_vec[MC_BIT]), 64'd1);
    mc_deq_req = 1; run_cycle();

    ctx = "R11 reset mid-run";
    inj(4, 16'h1, 16'h1, 32'h1, 32'h1); run_cycle();
    do_reset();

    ctx = "random R10 collisions";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(99) < 50)
        inj(int'($urandom_range(99) < 70 ? $urandom_range(2) : $urandom_range(7)),
            16'($urandom_range(2)), 16'($urandom_range(1)), $urandom, $urandom);
      if ($urandom_range(99) < 35) deq(8'($urandom));
      if ($urandom_range(99) < 10) begin
        clr_req = 1; clr_id = 16'($urandom_range(2)); clr_nr = 16'($urandom_range(1));
      end
      if ($urandom_range(99) < 15) begin svc_inj_valid = 1; svc_inj_parm = $urandom; end
      if ($urandom_range(99) < 10) svc_deq_req = 1;
      if ($urandom_range(99) < 8) mc_inj_valid = 1;
      if ($urandom_range(99) < 8) mc_deq_req = 1;
      run_cycle();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule